// File: doc/BRIEF.md
# Four-State One-Hot Sequencer with Clear-Only Reset

This block is a small synchronous control sequencer. It has four states and keeps them in one-hot form, with one flip-flop per state. Every flip-flop has only a synchronous clear and no preset. Next-state and output logic are sums of terms in which each term reads exactly one state bit. Each term therefore stays narrow, whatever the size of the machine.

A clear-only reset leaves every stored bit at zero, and zero is not a one-hot code. The parameter `START_MODE` picks one of two fixes. START_INVERTED stores the home-state bit in complemented form, so the all-zero pattern is the home state itself. START_SELF keeps plain one-hot storage and adds an all-zero detect term to the home-state equation. The machine then moves to the home state one clock after reset. The stored bits and the decoded active-sense state are both brought out. Two Mealy flags come from the current state and the condition inputs.

Top module: `onehot_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four stored bits become 0, so `state_bits` reads 4'b0000 after that edge.
- R2: With START_INVERTED, `state_bits` (bit i is state bit i) reads 4'b0000 for HOME, 4'b0011 for SPLIT, 4'b0101 for WAIT and 4'b1001 for HOLD. A reset therefore lands directly in HOME.
- R3: With START_SELF, `state_bits` is 1<<i for state i (HOME=0, SPLIT=1, WAIT=2, HOLD=3). From 4'b0000 with `rst` low, the next edge always gives HOME (4'b0001), whatever the other inputs. Both flags are 0 while the bits are 4'b0000.
- R4: From HOME: `cond_a` high goes to HOLD. Otherwise `advance` high goes to SPLIT. Otherwise the machine stays in HOME.
- R5: From SPLIT: `cond_b` high goes to HOLD, otherwise the machine goes to WAIT. It never stays in SPLIT.
- R6: From WAIT: `rewind` high goes to HOME, and takes priority. Otherwise `cond_c` high goes to HOLD. Otherwise the machine stays in WAIT.
- R7: From HOLD: `rewind` high goes to HOME. Otherwise `cond_d` high keeps the machine in HOLD. Otherwise it goes to HOME.
- R8: `flag_a` is combinationally `cond_a` in HOME or `cond_c` in WAIT, and 0 in other states.
- R9: `flag_b` is combinationally `cond_b` in SPLIT or `cond_d` in HOLD, and 0 in other states.
- R10: After any edge, `state_onehot` has exactly one bit set. The only exception is the all-zero pattern directly after a reset in START_SELF mode.
- R11: `state_onehot` bit i is 1 exactly when the machine is in state i (HOME=0 … HOLD=3), in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear of every state bit |
| advance | input | 1 | Leave HOME for SPLIT |
| rewind | input | 1 | Return from WAIT or HOLD to HOME |
| cond_a | input | 1 | HOME to HOLD arc; gates flag_a in HOME |
| cond_b | input | 1 | SPLIT to HOLD arc; gates flag_b in SPLIT |
| cond_c | input | 1 | WAIT to HOLD arc; gates flag_a in WAIT |
| cond_d | input | 1 | HOLD keep arc; gates flag_b in HOLD |
| flag_a | output | 1 | Mealy output A |
| flag_b | output | 1 | Mealy output B |
| state_bits | output | 4 | Stored flip-flop contents |
| state_onehot | output | 4 | Decoded active-sense state |

## Verification
The bench runs both modes side by side on a long biased input stream with frequent resets. It compares each mode against an arithmetic model of states, encodings and flags on every cycle. The stream targets three corner cases. One is the cycle right after reset in START_SELF, where a design missing the all-zero term stays dead at 0000 with no bit set. Another is the `rewind` against `cond_c` conflict in WAIT: if the priority is wrong, two state bits are set at once. The last is the inverted home bit. A design that forgets to complement it everywhere decodes HOME as empty and drives `flag_a` from the wrong state.

// File: rtl/onehot_seq_pkg.sv
package onehot_seq_pkg;
  typedef enum logic {
    START_INVERTED = 1'b0,
    START_SELF     = 1'b1
  } start_mode_e;

  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned S_HOME  = 0;
  localparam int unsigned S_SPLIT = 1;
  localparam int unsigned S_WAIT  = 2;
  localparam int unsigned S_HOLD  = 3;
endpackage

// File: rtl/onehot_sense_map.sv
// Converts between stored bits and active-sense one-hot bits.
// The map is its own inverse, so one module serves both directions.
module onehot_sense_map
  import onehot_seq_pkg::*;
#(
  parameter start_mode_e START_MODE = START_INVERTED,
  parameter int unsigned W = NUM_STATES
) (
  input  logic [W-1:0] in_bits,
  output logic [W-1:0] out_bits
);
  generate
    if (START_MODE == START_INVERTED) begin : g_inv
      assign out_bits = {in_bits[W-1:1], ~in_bits[0]};
    end else begin : g_plain
      assign out_bits = in_bits;
    end
  endgenerate
endmodule

// File: rtl/onehot_seq_reg.sv
// State flip-flops with synchronous clear only (no preset).
module onehot_seq_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/onehot_seq_next.sv
// Next-state equations in active sense; each term reads a single state bit.
module onehot_seq_next
  import onehot_seq_pkg::*;
#(
  parameter start_mode_e START_MODE = START_INVERTED
) (
  input  logic [NUM_STATES-1:0] cur,
  input  logic                  advance,
  input  logic                  rewind,
  input  logic                  cond_a,
  input  logic                  cond_b,
  input  logic                  cond_c,
  input  logic                  cond_d,
  output logic [NUM_STATES-1:0] nxt
);
  logic start_term;

  generate
    if (START_MODE == START_SELF) begin : g_self
      assign start_term = (cur == '0);
    end else begin : g_nostart
      assign start_term = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt[S_HOME]  = (cur[S_HOME] & ~cond_a & ~advance)
                 | (cur[S_WAIT] & rewind)
                 | (cur[S_HOLD] & (rewind | ~cond_d))
                 | start_term;
    nxt[S_SPLIT] = cur[S_HOME] & ~cond_a & advance;
    nxt[S_WAIT]  = (cur[S_SPLIT] & ~cond_b)
                 | (cur[S_WAIT] & ~rewind & ~cond_c);
    nxt[S_HOLD]  = (cur[S_HOME] & cond_a)
                 | (cur[S_SPLIT] & cond_b)
                 | (cur[S_WAIT] & ~rewind & cond_c)
                 | (cur[S_HOLD] & ~rewind & cond_d);
  end
endmodule

// File: rtl/onehot_seq_out.sv
// Mealy output equations, one state bit per term.
module onehot_seq_out
  import onehot_seq_pkg::*;
(
  input  logic [NUM_STATES-1:0] cur,
  input  logic                  cond_a,
  input  logic                  cond_b,
  input  logic                  cond_c,
  input  logic                  cond_d,
  output logic                  flag_a,
  output logic                  flag_b
);
  always_comb begin
    flag_a = (cond_a & cur[S_HOME]) | (cond_c & cur[S_WAIT]);
    flag_b = (cond_b & cur[S_SPLIT]) | (cond_d & cur[S_HOLD]);
  end
endmodule

// File: rtl/onehot_seq_ctrl.sv
module onehot_seq_ctrl
  import onehot_seq_pkg::*;
#(
  parameter start_mode_e START_MODE = START_INVERTED
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  advance,
  input  logic                  rewind,
  input  logic                  cond_a,
  input  logic                  cond_b,
  input  logic                  cond_c,
  input  logic                  cond_d,
  output logic                  flag_a,
  output logic                  flag_b,
  output logic [NUM_STATES-1:0] state_bits,
  output logic [NUM_STATES-1:0] state_onehot
);
  logic [NUM_STATES-1:0] stored_q;
  logic [NUM_STATES-1:0] stored_d;
  logic [NUM_STATES-1:0] cur_active;
  logic [NUM_STATES-1:0] nxt_active;

  onehot_seq_reg #(.W(NUM_STATES)) u_reg (
    .clk (clk), .rst (rst), .d (stored_d), .q (stored_q)
  );

  onehot_sense_map #(.START_MODE(START_MODE), .W(NUM_STATES)) u_decode (
    .in_bits (stored_q), .out_bits (cur_active)
  );

  onehot_seq_next #(.START_MODE(START_MODE)) u_next (
    .cur (cur_active), .advance (advance), .rewind (rewind),
    .cond_a (cond_a), .cond_b (cond_b), .cond_c (cond_c), .cond_d (cond_d),
    .nxt (nxt_active)
  );

  onehot_sense_map #(.START_MODE(START_MODE), .W(NUM_STATES)) u_encode (
    .in_bits (nxt_active), .out_bits (stored_d)
  );

  onehot_seq_out u_out (
    .cur (cur_active),
    .cond_a (cond_a), .cond_b (cond_b), .cond_c (cond_c), .cond_d (cond_d),
    .flag_a (flag_a), .flag_b (flag_b)
  );

  assign state_bits   = stored_q;
  assign state_onehot = cur_active;
endmodule

// File: rtl/onehot_seq_ctrl_chk.sv
module onehot_seq_ctrl_chk
  import onehot_seq_pkg::*;
#(
  parameter start_mode_e START_MODE = START_INVERTED
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rewind,
  input logic                  flag_a,
  input logic                  flag_b,
  input logic [NUM_STATES-1:0] state_bits,
  input logic [NUM_STATES-1:0] state_onehot
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk) rst |=> state_bits == '0);

  assert_onehot0_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    $onehot0(state_onehot));

  assert_flag_a_src_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    flag_a |-> (state_onehot[S_HOME] | state_onehot[S_WAIT]));

  assert_flag_b_src_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    flag_b |-> (state_onehot[S_SPLIT] | state_onehot[S_HOLD]));

  assert_split_leaves_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    state_onehot[S_SPLIT] |=> !state_onehot[S_SPLIT]);

  assert_rewind_home_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    ((state_onehot[S_WAIT] | state_onehot[S_HOLD]) && rewind) |=> state_onehot[S_HOME]);

  generate
    if (START_MODE == START_SELF) begin : g_self
      assert_selfstart_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_bits == '0) |=> (state_bits == 4'b0001));
    end else begin : g_inv
      assert_always_valid_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        $onehot(state_onehot));
    end
  endgenerate
endmodule

bind onehot_seq_ctrl onehot_seq_ctrl_chk #(.START_MODE(START_MODE)) u_chk (
  .clk (clk), .rst (rst), .rewind (rewind), .flag_a (flag_a), .flag_b (flag_b),
  .state_bits (state_bits), .state_onehot (state_onehot)
);

// File: tb/test_onehot_seq_ctrl.sv
`timescale 1ns/1ps
module test_onehot_seq_ctrl;
  import onehot_seq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advance = 1'b0, rewind = 1'b0;
  logic cond_a = 1'b0, cond_b = 1'b0, cond_c = 1'b0, cond_d = 1'b0;
  logic fa_i, fb_i, fa_s, fb_s;
  logic [3:0] bits_i, hot_i, bits_s, hot_s;

  int total = 0;
  int fails = 0;
  int m_inv = 0;
  int m_self = 4;
  string tag_inv = "R1";
  string tag_self = "R1";

  always #4 clk = ~clk;

  onehot_seq_ctrl #(.START_MODE(START_INVERTED)) i_onehot_seq_ctrl (
    .clk(clk), .rst(rst), .advance(advance), .rewind(rewind),
    .cond_a(cond_a), .cond_b(cond_b), .cond_c(cond_c), .cond_d(cond_d),
    .flag_a(fa_i), .flag_b(fb_i), .state_bits(bits_i), .state_onehot(hot_i));

  onehot_seq_ctrl #(.START_MODE(START_SELF)) i_onehot_seq_ctrl_self (
    .clk(clk), .rst(rst), .advance(advance), .rewind(rewind),
    .cond_a(cond_a), .cond_b(cond_b), .cond_c(cond_c), .cond_d(cond_d),
    .flag_a(fa_s), .flag_b(fb_s), .state_bits(bits_s), .state_onehot(hot_s));

  // state 4 means the all-zero startup pattern
  function automatic int next_of(int s);
    case (s)
      4: return 0;
      0: return cond_a ? 3 : (advance ? 1 : 0);
      1: return cond_b ? 3 : 2;
      2: return rewind ? 0 : (cond_c ? 3 : 2);
      default: return rewind ? 0 : (cond_d ? 3 : 0);
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      4: return "R3";
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [3:0] raw_of(int s, bit inv);
    if (s == 4) return 4'b0000;
    if (!inv) return 4'b0001 << s;
    case (s)
      0: return 4'b0000;
      1: return 4'b0011;
      2: return 4'b0101;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic logic [3:0] hot_of(int s);
    return (s == 4) ? 4'b0000 : (4'b0001 << s);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_one(string nm, bit inv, int s, string tg,
                           logic [3:0] bits, logic [3:0] hot, logic fa, logic fb);
    logic ea, eb;
    ea = (s == 0 && cond_a) || (s == 2 && cond_c);
    eb = (s == 1 && cond_b) || (s == 3 && cond_d);
    chk(bits === raw_of(s, inv), inv ? "R2" : "R3", {nm, " state_bits after ", tg},
        int'(bits), int'(raw_of(s, inv)));
    chk(hot === hot_of(s), tg, {nm, " state_onehot (R11)"}, int'(hot), int'(hot_of(s)));
    if (s != 4)
      chk($countones(hot) == 1, "R10", {nm, " one-hot count"}, $countones(hot), 1);
    chk(fa === ea, (s == 4) ? "R3" : "R8", {nm, " flag_a"}, int'(fa), int'(ea));
    chk(fb === eb, (s == 4) ? "R3" : "R9", {nm, " flag_b"}, int'(fb), int'(eb));
  endtask

  task automatic step(bit r, bit ad, bit rw, bit ca, bit cb, bit cc, bit cd);
    @(negedge clk);
    rst = r; advance = ad; rewind = rw;
    cond_a = ca; cond_b = cb; cond_c = cc; cond_d = cd;
    #1;
    check_one("inv",  1'b1, m_inv,  tag_inv,  bits_i, hot_i, fa_i, fb_i);
    check_one("self", 1'b0, m_self, tag_self, bits_s, hot_s, fa_s, fb_s);
    @(posedge clk);
    if (r) begin
      m_inv = 0; m_self = 4; tag_inv = "R1"; tag_self = "R1";
    end else begin
      tag_inv = tag_of(m_inv);   m_inv = next_of(m_inv);
      tag_self = tag_of(m_self); m_self = next_of(m_self);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    m_inv = 0; m_self = 4;
    // R1 R2 R3: reset state, then self-start with inputs all high
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    // R6 priority: reach WAIT (HOME->SPLIT->WAIT), then rewind with cond_c high
    step(1'b1, 0, 0, 0, 0, 0, 0);
    step(1'b0, 1, 0, 0, 0, 0, 0);
    step(1'b0, 1, 0, 0, 0, 0, 0);
    step(1'b0, 1, 0, 0, 0, 0, 0);
    step(1'b0, 0, 1, 0, 0, 1, 0);
    step(1'b0, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 6000; n++) begin
      bit r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = (lfsr[5:0] == 6'd0);
      step(r, lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[9],
           lfsr[6], lfsr[7], lfsr[8] | lfsr[11]);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule